// File: doc/BRIEF.md
# Dual-Channel Shared-Bus Output Stage

This block is the digital back end of a two-channel sampling converter. Two 12-bit sample codes, one for the in-phase (I) lane and one for the quadrature (Q) lane, are captured together on every rising clock edge. Each code is delayed to match the converter's pipeline latency. Both lanes then share a single 12-bit output bus through a channel-select multiplexer.

The select can be held static to present one lane. It can also follow the clock, which interleaves I in the high phase and Q in the low phase. The Q lane lags I by an extra half cycle because it is retimed on the falling edge. An active-low enable floats the bus, and a pad-enable output is provided for the I/O ring. Sampling and the delay line keep running while the bus floats.

A valid flag marks the first cycle in which the bus carries a sample captured after reset, rather than the cleared pipeline contents.

Top module: `dual_bus_out`

## Requirements
- R1: The I code present at rising edge k is on the bus during the clock cycle that follows rising edge k+7, when I is selected.
- R2: The Q code present at rising edge k appears on the bus from the falling edge after rising edge k+7 and is held until the next falling edge, when Q is selected.
- R3: In static mode (`sel_clock_mode` = 0), `sel_i_hi` = 1 puts the I word on the bus and `sel_i_hi` = 0 puts the Q word on the bus.
- R4: In clock-following mode (`sel_clock_mode` = 1), the bus carries the I word while `clk` is high and the Q word while `clk` is low, and `sel_i_hi` has no effect.
- R5: While `oe_n` = 1, `bus_drive` is 0 and all 12 bus bits are high impedance, but sampling continues. When `oe_n` returns to 0, the bus shows the current pipeline word in the same cycle, with no added latency.
- R6: After reset is released, `bus_valid` stays 0 through the first 7 rising edges and becomes 1 at the 8th rising edge, which brings the first post-reset sample to the bus. It then stays 1 until the next reset.
- R7: The synchronous active-high reset `rst` clears both lanes of the delay line and the Q retiming register to code 0 and clears `bus_valid`. Until the first sample arrives, the bus shows 0.
- R8: Codes are 12-bit straight binary, with bit 11 as the MSB and bit 0 as the LSB. They pass through unchanged, including the extremes 0x000 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; both lanes capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 12 | I-lane raw code |
| smp_q | input | 12 | Q-lane raw code |
| sel_clock_mode | input | 1 | 1: select follows clk; 0: static select |
| sel_i_hi | input | 1 | Static select: 1 = I, 0 = Q |
| oe_n | input | 1 | Active-low output enable |
| bus_out | output | 12 | Shared tri-state data bus |
| bus_drive | output | 1 | Pad enable, high when bus_out is driven |
| bus_valid | output | 1 | High once the pipeline holds post-reset samples |

## Verification
The bench builds the block with the default latency of 7 and the 12-bit word. This makes the full fill sequence after reset short enough to walk edge by edge. It also places the R1 and R2 lags at exact edge counts that the reference model computes from a closed-form stimulus.

A separate pattern generator per lane makes any I/Q swap or half-cycle slip visible. Each value is sampled in both clock phases, which separates the falling-edge Q timing from the rising-edge I timing in both select modes. The stimulus injects 0x000 and 0xFFF periodically to cover the code extremes.

// File: rtl/dbo_pkg.sv
package dbo_pkg;

    localparam int unsigned DBO_WORD_W = 12;

    typedef logic [DBO_WORD_W-1:0] word_t;

    typedef struct packed {
        word_t i;
        word_t q;
    } lane_pair_t;

    typedef enum logic {
        SEL_STATIC = 1'b0,
        SEL_CLOCK  = 1'b1
    } sel_mode_e;

    // Chooses the I lane when the effective select is high.
    function automatic word_t pick_lane(input logic take_i, input word_t i_w, input word_t q_w);
        return take_i ? i_w : q_w;
    endfunction

endpackage

// File: rtl/dbo_lane_delay.sv
module dbo_lane_delay
    import dbo_pkg::*;
#(
    parameter int unsigned STAGES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  lane_pair_t din,
    output lane_pair_t dout
);

    lane_pair_t stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dbo_q_retime.sv
module dbo_q_retime
    import dbo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t q_in,
    output word_t q_out
);

    // Falling-edge capture gives the Q lane its extra half cycle.
    always_ff @(negedge clk) begin
        if (rst) q_out <= '0;
        else     q_out <= q_in;
    end

endmodule

// File: rtl/dbo_fill_track.sv
module dbo_fill_track #(
    parameter int unsigned FILL_EDGES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic filled
);

    localparam int unsigned CNT_W = $clog2(FILL_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILL_EDGES);

    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst)                    edge_cnt <= '0;
        else if (edge_cnt != CNT_TOP) edge_cnt <= edge_cnt + 1'b1;
    end

    assign filled = (edge_cnt == CNT_TOP);

endmodule

// File: rtl/dbo_bus_mux.sv
module dbo_bus_mux
    import dbo_pkg::*;
(
    input  logic      clk,
    input  sel_mode_e mode,
    input  logic      sel_i_hi,
    input  word_t     i_word,
    input  word_t     q_word,
    output word_t     mux_word
);

    logic take_i;

    always_comb begin
        unique case (mode)
            SEL_CLOCK:  take_i = clk;
            default:    take_i = sel_i_hi;
        endcase
        mux_word = pick_lane(take_i, i_word, q_word);
    end

endmodule

// File: rtl/dual_bus_out.sv
module dual_bus_out
    import dbo_pkg::*;
#(
    parameter int unsigned LATENCY = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DBO_WORD_W-1:0] smp_i,
    input  logic [DBO_WORD_W-1:0] smp_q,
    input  logic                  sel_clock_mode,
    input  logic                  sel_i_hi,
    input  logic                  oe_n,
    output logic [DBO_WORD_W-1:0] bus_out,
    output logic                  bus_drive,
    output logic                  bus_valid
);

    // One capture register plus LATENCY delay stages.
    localparam int unsigned STAGES = LATENCY + 1;

    lane_pair_t lane_in;
    lane_pair_t lane_tail;
    word_t      i_tail;
    word_t      q_tail;
    word_t      q_half;
    word_t      mux_word;
    sel_mode_e  mode;

    assign lane_in.i = smp_i;
    assign lane_in.q = smp_q;
    assign mode      = sel_mode_e'(sel_clock_mode);

    dbo_lane_delay #(.STAGES(STAGES)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (lane_in),
        .dout (lane_tail)
    );

    assign i_tail = lane_tail.i;
    assign q_tail = lane_tail.q;

    dbo_q_retime u_qret (
        .clk   (clk),
        .rst   (rst),
        .q_in  (q_tail),
        .q_out (q_half)
    );

    dbo_bus_mux u_mux (
        .clk      (clk),
        .mode     (mode),
        .sel_i_hi (sel_i_hi),
        .i_word   (i_tail),
        .q_word   (q_half),
        .mux_word (mux_word)
    );

    dbo_fill_track #(.FILL_EDGES(STAGES)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .filled (bus_valid)
    );

    assign bus_drive = ~oe_n;
    assign bus_out   = bus_drive ? mux_word : {DBO_WORD_W{1'bz}};

endmodule

// File: rtl/dbo_checker.sv
module dbo_checker
    import dbo_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sel_clock_mode,
    input logic  sel_i_hi,
    input word_t mux_word,
    input word_t i_tail,
    input word_t q_tail,
    input word_t q_half,
    input logic  bus_valid
);

    AST_STATIC_I_PATH: assert property (@(posedge clk) disable iff (rst)
        (!sel_clock_mode && sel_i_hi) |-> (mux_word == i_tail)); // R3

    AST_STATIC_Q_PATH: assert property (@(posedge clk) disable iff (rst)
        (!sel_clock_mode && !sel_i_hi) |-> (mux_word == q_half)); // R3

    AST_Q_HALF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (q_half == q_tail)); // R2

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> bus_valid); // R6

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_valid && i_tail == '0 && q_half == '0)); // R7

endmodule

bind dual_bus_out dbo_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_clock_mode (sel_clock_mode),
    .sel_i_hi       (sel_i_hi),
    .mux_word       (mux_word),
    .i_tail         (i_tail),
    .q_tail         (q_tail),
    .q_half         (q_half),
    .bus_valid      (bus_valid)
);

// File: tb/dual_bus_out_test.sv
module dual_bus_out_test;

    localparam int LAT = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] smp_i = '0;
    logic [11:0] smp_q = '0;
    logic        sel_clock_mode = 1'b0;
    logic        sel_i_hi = 1'b1;
    logic        oe_n = 1'b0;
    wire  [11:0] bus_out;
    logic        bus_drive;
    logic        bus_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int e      = 0;
    int seed   = 17;
    int wd     = 0;

    always #10 clk = ~clk;

    dual_bus_out #(.LATENCY(LAT)) uut (
        .clk            (clk),
        .rst            (rst),
        .smp_i          (smp_i),
        .smp_q          (smp_q),
        .sel_clock_mode (sel_clock_mode),
        .sel_i_hi       (sel_i_hi),
        .oe_n           (oe_n),
        .bus_out        (bus_out),
        .bus_drive      (bus_drive),
        .bus_valid      (bus_valid)
    );

    // {follow, sel_i, oe_n, cycles}
    localparam logic [10:0] PLAN [10] = '{
        {1'b0, 1'b1, 1'b0, 8'd12},
        {1'b0, 1'b0, 1'b0, 8'd10},
        {1'b1, 1'b1, 1'b0, 8'd10},
        {1'b1, 1'b0, 1'b0, 8'd6},
        {1'b0, 1'b1, 1'b1, 8'd4},
        {1'b0, 1'b1, 1'b0, 8'd3},
        {1'b1, 1'b0, 1'b1, 8'd3},
        {1'b1, 1'b0, 1'b0, 8'd4},
        {1'b0, 1'b0, 1'b1, 8'd2},
        {1'b0, 1'b0, 1'b0, 8'd8}
    };

    function automatic logic [11:0] fi(input int k);
        if (k < 1)         return 12'h000;
        if (k % 13 == 5)   return 12'hFFF;
        if (k % 13 == 6)   return 12'h000;
        return 12'((k * 613 + seed) & 32'hFFF);
    endfunction

    function automatic logic [11:0] fq(input int k);
        if (k < 1)         return 12'h000;
        if (k % 11 == 2)   return 12'hFFF;
        if (k % 11 == 9)   return 12'h000;
        return 12'(((k * 1877) ^ (seed * 3)) & 32'hFFF);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %h expected %h", req, e, act, exp);
        end
    endtask

    // Check the bus in one phase; hi_phase selects which expectation applies.
    task automatic check_phase(input bit hi_phase);
        logic [11:0] exp_w;
        bit take_i;
        take_i = sel_clock_mode ? hi_phase : sel_i_hi;
        if (take_i)        exp_w = fi(e - LAT);
        else if (hi_phase) exp_w = fq(e - LAT - 1);
        else               exp_w = fq(e - LAT);
        chk(bus_valid == (e >= LAT + 1), "R6 valid", {11'd0, bus_valid}, {11'd0, (e >= LAT + 1)});
        if (oe_n) begin
            chk(bus_drive == 1'b0, "R5 float", {11'd0, bus_drive}, 12'd0);
        end else begin
            chk(bus_drive == 1'b1, "R5 drive", {11'd0, bus_drive}, 12'd1);
            if (sel_clock_mode)
                chk(bus_out == exp_w, hi_phase ? "R4 I phase" : "R4 Q phase", bus_out, exp_w);
            else if (take_i)
                chk(bus_out == exp_w, "R1/R3 I word", bus_out, exp_w);
            else
                chk(bus_out == exp_w, "R2/R3 Q word", bus_out, exp_w);
        end
    endtask

    task automatic tick(input bit follow, input bit sel, input bit oen);
        @(posedge clk);
        if (!rst) e++;
        #2;
        sel_clock_mode = follow;
        sel_i_hi       = sel;
        oe_n           = oen;
        #3;
        smp_i = fi(e + 1);
        smp_q = fq(e + 1);
        #3;
        check_phase(1'b1);
        #10;
        check_phase(1'b0);
    endtask

    task automatic do_reset(input int new_seed);
        @(posedge clk);
        #5 rst = 1'b1;
        repeat (2) @(posedge clk);
        #8;
        // R7: cleared pipeline, bus shows 0 and valid low while in reset
        chk(bus_out == 12'h000, "R7 reset bus", bus_out, 12'h000);
        chk(bus_valid == 1'b0, "R7 reset valid", {11'd0, bus_valid}, 12'd0);
        seed = new_seed;
        e = 0;
        rst = 1'b0;
        smp_i = fi(1);
        smp_q = fq(1);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements: actual %0d cycles expected below %0d", wd, 100000);
            summary();
            $finish;
        end
    end

    initial begin
        sel_i_hi = 1'b1;
        oe_n     = 1'b0;
        do_reset(17);

        // R6 R7: fill sequence walked edge by edge, bus stays 0 until edge 8
        for (int k = 0; k < LAT + 3; k++) tick(1'b0, 1'b1, 1'b0);

        // Table walk over select modes and output enable (R1..R5, R8)
        for (int p = 0; p < 10; p++) begin
            for (int c = 0; c < int'(PLAN[p][7:0]); c++)
                tick(PLAN[p][10], PLAN[p][9], PLAN[p][8]);
        end

        // R4: sel_i_hi toggled in clock mode has no effect
        for (int c = 0; c < 6; c++) tick(1'b1, c[0], 1'b0);

        // R5: long float then immediate valid data on re-enable
        for (int c = 0; c < 9; c++) tick(1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0);

        // R7 R6: reset mid-run with a new pattern, then refill
        do_reset(911);
        for (int k = 0; k < LAT + 6; k++) tick(1'b0, k[1], 1'b0);
        for (int k = 0; k < 30; k++) tick(k[2], k[0], 1'b0);

        // R8: extremes forced through both lanes
        tick(1'b0, 1'b1, 1'b0);
        smp_i = 12'hFFF;
        smp_q = 12'h000;
        begin
            int cap;
            logic [11:0] got;
            @(posedge clk);
            e++;
            cap = e;
            #5 smp_i = 12'h000;
            smp_q = 12'hFFF;
            @(posedge clk);
            e++;
            repeat (LAT - 1) begin
                @(posedge clk);
                e++;
            end
            #8;
            sel_i_hi = 1'b1;
            #1 got = bus_out;
            chk(got == 12'hFFF, "R8 I max", got, 12'hFFF);
            #9;
            sel_i_hi = 1'b0;
            #1 got = bus_out;
            chk(got == 12'h000, "R8 Q min", got, 12'h000);
            if (e != cap + LAT) $display("note: edge bookkeeping %0d", e);
            @(posedge clk);
            #8 sel_i_hi = 1'b1;
            #1 got = bus_out;
            chk(got == 12'h000, "R8 I min", got, 12'h000);
            #9 sel_i_hi = 1'b0;
            #1 got = bus_out;
            chk(got == 12'hFFF, "R8 Q max", got, 12'hFFF);
        end

        summary();
        $finish;
    end

endmodule